// File: doc/BRIEF.md
# Network Controller Host Register File

This block is the register window a host processor uses to command and observe a network controller. The host sees only two 16-bit locations: a pointer location that selects one internal register, and a data location that reads or writes whichever register the pointer currently selects. Behind that window sit a command/status word, the address of the initialization block in memory, a bus-control word, a 64-bit multicast filter held as four words, and a promiscuous-receive flag.

The command/status word mixes several bit kinds. Command bits latch when a 1 is written and leave single-cycle strobes for the controller's engines. Engine state bits are read-only. An enable bit is plain read/write. Event flags are raised by pulses from the receive and transmit engines and cleared by writing 1. Two summary bits are derived from the flags, and an interrupt line follows them when the enable bit is set. The stop command dominates everything else in the same write. It returns the controller to an idle, quiet state and clears the bus-control word. While the controller is stopped, the host may rewrite the configuration registers.

Top module: `nic_csr_file`

## Requirements
- R1: After reset the status word (register 0) reads 0x0004, with only the stop bit set. The pointer reads 0, the interrupt line is low and all strobes are low.
- R2: In register 0, writing 1 to bit 0 (init) or bit 1 (start) latches that bit and clears stop (bit 2). Start also sets the transmitter-on bit (bit 4) and the receiver-on bit (bit 5). Bit 6 (interrupt enable) takes the written value on every write to register 0. Writing 0 to bits 0 to 3 leaves them unchanged. Data on bits 4, 5, 7 and 15 has no effect.
- R3: A write to register 0 with bit 2 set leaves the status word as 0x0004 plus the written bit 6. This holds even when bits 0, 1 or 3 are also written. It clears init, start, transmit demand (bit 3), both on-bits and every event flag.
- R4: A stop write clears the bus-control word in register 3, including its byte-swap bit (bit 2).
- R5: Event flags occupy bits 8 to 14 in this order: init-done, tx-done, rx-done, memory error, missed frame, carrier error, babble. Each event pulse sets its flag at the next clock edge. Writing 1 to a flag bit clears it, and an event in the same cycle wins. Events arriving while stop is set are ignored.
- R6: Bit 15 is the OR of bits 11 to 14. Bit 7 is the OR of bit 15 with bits 8, 9 and 10. The interrupt output equals bit 7 AND bit 6.
- R7: Each command strobe is a one-cycle pulse in the cycle after the write. init_strobe_o pulses for bit 0 and start_strobe_o for bit 1, provided bit 2 is clear. stop_strobe_o pulses for bit 2. tx_demand_strobe_o pulses for bit 3 only if the controller is not stopped after that write, and only then does bit 3 latch. A tx-done event clears bit 3.
- R8: A write to the pointer location loads the low 4 data bits as the register select, and a read of the pointer location returns the select. The data location reads the selected register. Unmapped registers (4 to 7, 12 to 14) read 0 and ignore writes.
- R9: Register 1 holds the low 16 bits of the init-block address and register 2 the high 8 bits (bits 7:0), and init_addr_o is {register 2, register 1}. Register 3 holds bus control in bits 2:0, driven on bus_ctl_o.
- R10: Registers 8, 9, 10 and 11 hold mcast_filter_o bits 15:0, 31:16, 47:32 and 63:48. Bit 15 of register 15 drives promisc_o.
- R11: Registers other than 0 accept writes only while stop is set, judged before the write. Writes at other times leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_port | input | 1 | 1 selects the pointer location, 0 the data location |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data of the selected location |
| init_done_i | input | 1 | Init-block fetch finished |
| tx_done_i | input | 1 | Transmit engine finished a frame |
| rx_done_i | input | 1 | Receive engine delivered a frame |
| mem_err_i | input | 1 | Memory access failure |
| miss_i | input | 1 | Frame dropped for lack of a buffer |
| carrier_err_i | input | 1 | Carrier or heartbeat fault |
| babble_i | input | 1 | Transmitter exceeded maximum frame length |
| irq_o | output | 1 | Interrupt request |
| init_strobe_o | output | 1 | Start fetching the init block |
| start_strobe_o | output | 1 | Enable the engines |
| stop_strobe_o | output | 1 | Halt the engines |
| tx_demand_strobe_o | output | 1 | Poll the transmit ring now |
| init_addr_o | output | 24 | Init-block address |
| bus_ctl_o | output | 3 | Bus-control bits (byte-swap in bit 2) |
| mcast_filter_o | output | 64 | Multicast hash filter |
| promisc_o | output | 1 | Accept all frames |

## Verification
The hardest states to reach are the ones where several rules act on the status word in one cycle. One case is an event pulse that coincides with a write-one-to-clear of the same flag. Another is a stop write that carries init, start and a nonzero interrupt enable together. A third is an event, or a transmit demand, that arrives while the block is stopped. The stimulus first configures the block while stopped, then starts it. It then drives an event and a host write in the very same cycle, and later issues combined stop and command writes. A cycle-by-cycle model predicts every output throughout, so each of these collisions is compared at the ports in the cycle it resolves.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;

    localparam int WORD_W    = 16;
    localparam int BUSCTL_W  = 3;
    localparam int FLAG_LSB  = 8;
    localparam int FLAG_W    = 7;

    // register numbers seen through the pointer
    localparam int REG_STATUS   = 0;
    localparam int REG_IADDR_LO = 1;
    localparam int REG_IADDR_HI = 2;
    localparam int REG_BUSCTL   = 3;
    localparam int REG_FILT0    = 8;
    localparam int REG_PROMISC  = 15;

    // command bit positions in the status word
    localparam int CMD_INIT  = 0;
    localparam int CMD_START = 1;
    localparam int CMD_STOP  = 2;
    localparam int CMD_TDMD  = 3;
    localparam int BIT_INEA  = 6;

    // field order equals status bits 14 down to 8
    typedef struct packed {
        logic babl;
        logic cerr;
        logic miss;
        logic merr;
        logic rint;
        logic tint;
        logic idon;
    } flags_t;

    // field order equals status bits 6 down to 0
    typedef struct packed {
        logic inea;
        logic rxon;
        logic txon;
        logic tdmd;
        logic stop;
        logic strt;
        logic init;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{inea: 1'b0, rxon: 1'b0, txon: 1'b0, tdmd: 1'b0,
                                  stop: 1'b1, strt: 1'b0, init: 1'b0};

    function automatic logic err_sum(flags_t f);
        return f.babl | f.cerr | f.miss | f.merr;
    endfunction

    function automatic logic intr_sum(flags_t f);
        return err_sum(f) | f.idon | f.tint | f.rint;
    endfunction

    function automatic logic [WORD_W-1:0] status_word(ctl_t c, flags_t f);
        return {err_sum(f), f, intr_sum(f), c};
    endfunction

endpackage

// File: rtl/nic_csr_status.sv
module nic_csr_status
    import nic_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    input  flags_t            events,
    output ctl_t              ctl_o,
    output flags_t            flags_o,
    output logic              init_stb_o,
    output logic              start_stb_o,
    output logic              stop_stb_o,
    output logic              tdmd_stb_o
);

    ctl_t   ctl_q, ctl_n;
    flags_t flags_q, flags_n;
    flags_t w1c;
    logic   stop_req;
    logic   tdmd_go;

    assign w1c      = flags_t'(wdata[FLAG_LSB +: FLAG_W]);
    assign stop_req = wr_en && wdata[CMD_STOP];

    // read-only positions carry no write effect
    wire unused_ro_bits = ^{wdata[15], wdata[7], wdata[5:4]};

    always_comb begin
        ctl_n   = ctl_q;
        flags_n = wr_en ? flags_t'(flags_q & ~w1c) : flags_q;
        tdmd_go = 1'b0;
        if (!ctl_q.stop) begin
            flags_n = flags_t'(flags_n | events);
            if (events.tint) ctl_n.tdmd = 1'b0;
        end
        if (wr_en) begin
            if (stop_req) begin
                ctl_n   = CTL_IDLE;
                flags_n = '0;
            end else begin
                if (wdata[CMD_INIT]) begin
                    ctl_n.init = 1'b1;
                    ctl_n.stop = 1'b0;
                end
                if (wdata[CMD_START]) begin
                    ctl_n.strt = 1'b1;
                    ctl_n.stop = 1'b0;
                    ctl_n.txon = 1'b1;
                    ctl_n.rxon = 1'b1;
                end
                if (wdata[CMD_TDMD] && !ctl_n.stop) begin
                    ctl_n.tdmd = 1'b1;
                    tdmd_go    = 1'b1;
                end
            end
            ctl_n.inea = wdata[BIT_INEA];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q       <= CTL_IDLE;
            flags_q     <= '0;
            init_stb_o  <= 1'b0;
            start_stb_o <= 1'b0;
            stop_stb_o  <= 1'b0;
            tdmd_stb_o  <= 1'b0;
        end else begin
            ctl_q       <= ctl_n;
            flags_q     <= flags_n;
            init_stb_o  <= wr_en && !stop_req && wdata[CMD_INIT];
            start_stb_o <= wr_en && !stop_req && wdata[CMD_START];
            stop_stb_o  <= stop_req;
            tdmd_stb_o  <= tdmd_go;
        end
    end

    assign ctl_o   = ctl_q;
    assign flags_o = flags_q;

endmodule

// File: rtl/nic_csr_aux.sv
module nic_csr_aux
    import nic_csr_pkg::*;
#(
    parameter int PTR_W      = 4,
    parameter int ADDR_HI_W  = 8,
    parameter int FILT_WORDS = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic                         unlocked,
    input  logic                         bus_clr,
    input  logic [PTR_W-1:0]             sel,
    input  logic [WORD_W-1:0]            wdata,
    output logic [WORD_W+ADDR_HI_W-1:0]  iaddr_o,
    output logic [BUSCTL_W-1:0]          busctl_o,
    output logic [FILT_WORDS*WORD_W-1:0] filt_o,
    output logic                         promisc_o,
    output logic [WORD_W-1:0]            rdata_o
);

    logic                 we_ok;
    logic [WORD_W-1:0]    lo_q;
    logic [ADDR_HI_W-1:0] hi_q;
    logic [BUSCTL_W-1:0]  bus_q;
    logic                 prom_q;

    assign we_ok = wr_en && unlocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= '0;
            hi_q   <= '0;
            prom_q <= 1'b0;
        end else if (we_ok) begin
            if (sel == PTR_W'(REG_IADDR_LO)) lo_q   <= wdata;
            if (sel == PTR_W'(REG_IADDR_HI)) hi_q   <= wdata[ADDR_HI_W-1:0];
            if (sel == PTR_W'(REG_PROMISC))  prom_q <= wdata[WORD_W-1];
        end
    end

    // stop clears bus control whatever else happens
    always_ff @(posedge clk) begin
        if (rst || bus_clr)
            bus_q <= '0;
        else if (we_ok && sel == PTR_W'(REG_BUSCTL))
            bus_q <= wdata[BUSCTL_W-1:0];
    end

    for (genvar gi = 0; gi < FILT_WORDS; gi++) begin : g_filt
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '0;
            else if (we_ok && sel == PTR_W'(REG_FILT0 + gi))
                word_q <= wdata;
        end
        assign filt_o[gi*WORD_W +: WORD_W] = word_q;
    end

    always_comb begin
        rdata_o = '0;
        if (sel == PTR_W'(REG_IADDR_LO)) rdata_o = lo_q;
        if (sel == PTR_W'(REG_IADDR_HI)) rdata_o = WORD_W'(hi_q);
        if (sel == PTR_W'(REG_BUSCTL))   rdata_o = WORD_W'(bus_q);
        if (sel == PTR_W'(REG_PROMISC))  rdata_o = {prom_q, {(WORD_W-1){1'b0}}};
        for (int i = 0; i < FILT_WORDS; i++)
            if (sel == PTR_W'(REG_FILT0 + i)) rdata_o = filt_o[i*WORD_W +: WORD_W];
    end

    assign iaddr_o   = {hi_q, lo_q};
    assign busctl_o  = bus_q;
    assign promisc_o = prom_q;

endmodule

// File: rtl/nic_csr_file.sv
module nic_csr_file
    import nic_csr_pkg::*;
#(
    parameter int PTR_W      = 4,
    parameter int ADDR_HI_W  = 8,
    parameter int FILT_WORDS = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         host_we,
    input  logic                         host_port,
    input  logic [WORD_W-1:0]            host_wdata,
    output logic [WORD_W-1:0]            host_rdata,
    input  logic                         init_done_i,
    input  logic                         tx_done_i,
    input  logic                         rx_done_i,
    input  logic                         mem_err_i,
    input  logic                         miss_i,
    input  logic                         carrier_err_i,
    input  logic                         babble_i,
    output logic                         irq_o,
    output logic                         init_strobe_o,
    output logic                         start_strobe_o,
    output logic                         stop_strobe_o,
    output logic                         tx_demand_strobe_o,
    output logic [WORD_W+ADDR_HI_W-1:0]  init_addr_o,
    output logic [BUSCTL_W-1:0]          bus_ctl_o,
    output logic [FILT_WORDS*WORD_W-1:0] mcast_filter_o,
    output logic                         promisc_o
);

    logic [PTR_W-1:0]  ptr_q;
    logic              data_we;
    logic              sel_status;
    ctl_t              st_ctl;
    flags_t            st_flags;
    flags_t            evt;
    logic [WORD_W-1:0] aux_rdata;

    assign data_we    = host_we && !host_port;
    assign sel_status = (ptr_q == PTR_W'(REG_STATUS));
    assign evt        = '{babl: babble_i, cerr: carrier_err_i, miss: miss_i,
                          merr: mem_err_i, rint: rx_done_i, tint: tx_done_i,
                          idon: init_done_i};

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (host_we && host_port)
            ptr_q <= host_wdata[PTR_W-1:0];
    end

    nic_csr_status u_status (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (data_we && sel_status),
        .wdata       (host_wdata),
        .events      (evt),
        .ctl_o       (st_ctl),
        .flags_o     (st_flags),
        .init_stb_o  (init_strobe_o),
        .start_stb_o (start_strobe_o),
        .stop_stb_o  (stop_strobe_o),
        .tdmd_stb_o  (tx_demand_strobe_o)
    );

    nic_csr_aux #(
        .PTR_W      (PTR_W),
        .ADDR_HI_W  (ADDR_HI_W),
        .FILT_WORDS (FILT_WORDS)
    ) u_aux (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (data_we && !sel_status),
        .unlocked  (st_ctl.stop),
        .bus_clr   (data_we && sel_status && host_wdata[CMD_STOP]),
        .sel       (ptr_q),
        .wdata     (host_wdata),
        .iaddr_o   (init_addr_o),
        .busctl_o  (bus_ctl_o),
        .filt_o    (mcast_filter_o),
        .promisc_o (promisc_o),
        .rdata_o   (aux_rdata)
    );

    assign irq_o = intr_sum(st_flags) & st_ctl.inea;

    always_comb begin
        if (host_port)
            host_rdata = WORD_W'(ptr_q);
        else if (sel_status)
            host_rdata = status_word(st_ctl, st_flags);
        else
            host_rdata = aux_rdata;
    end

endmodule

// File: rtl/nic_csr_file_chk.sv
module nic_csr_file_chk
    import nic_csr_pkg::*;
#(
    parameter int ADDR_HI_W  = 8,
    parameter int FILT_WORDS = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         data_we,
    input logic                         ptr_is_status,
    input logic                         stop_bit,
    input ctl_t                         ctl,
    input flags_t                       flags,
    input logic                         irq,
    input logic                         init_stb,
    input logic                         start_stb,
    input logic                         stop_stb,
    input logic                         tdmd_stb,
    input logic [WORD_W+ADDR_HI_W-1:0]  iaddr,
    input logic [BUSCTL_W-1:0]          busctl,
    input logic [FILT_WORDS*WORD_W-1:0] filt,
    input logic                         promisc
);

    AST_STOP_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (data_we && ptr_is_status && stop_bit) |=>
            (ctl.stop && !ctl.init && !ctl.strt && !ctl.tdmd && !ctl.txon && !ctl.rxon && flags == '0)); // R3

    AST_STOP_CLEARS_BUSCTL: assert property (@(posedge clk) disable iff (rst)
        (data_we && ptr_is_status && stop_bit) |=> (busctl == '0)); // R4

    AST_CONFIG_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (data_we && !ptr_is_status && !ctl.stop) |=>
            ($stable(iaddr) && $stable(busctl) && $stable(filt) && $stable(promisc))); // R11

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        irq |-> ctl.inea); // R6

    AST_QUIET_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
        ctl.stop |-> (flags == '0 && !irq)); // R5

    AST_STOP_STROBE_ALONE: assert property (@(posedge clk) disable iff (rst)
        stop_stb |-> !(init_stb || start_stb || tdmd_stb)); // R7

    AST_START_STROBE_STATE: assert property (@(posedge clk) disable iff (rst)
        start_stb |-> (ctl.strt && ctl.txon && ctl.rxon && !ctl.stop)); // R7

    AST_TDMD_ONLY_RUNNING: assert property (@(posedge clk) disable iff (rst)
        tdmd_stb |-> (ctl.tdmd && !ctl.stop)); // R7

endmodule

bind nic_csr_file nic_csr_file_chk #(
    .ADDR_HI_W  (ADDR_HI_W),
    .FILT_WORDS (FILT_WORDS)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .data_we       (host_we && !host_port),
    .ptr_is_status (ptr_q == '0),
    .stop_bit      (host_wdata[2]),
    .ctl           (st_ctl),
    .flags         (st_flags),
    .irq           (irq_o),
    .init_stb      (init_strobe_o),
    .start_stb     (start_strobe_o),
    .stop_stb      (stop_strobe_o),
    .tdmd_stb      (tx_demand_strobe_o),
    .iaddr         (init_addr_o),
    .busctl        (bus_ctl_o),
    .filt          (mcast_filter_o),
    .promisc       (promisc_o)
);

// File: tb/nic_csr_file_bench.sv
module nic_csr_file_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic        port = 1'b0;
    logic [15:0] wd = '0;
    logic [6:0]  ev = '0;   // 0 init-done .. 6 babble

    logic [15:0] rdata;
    logic        irq, s_init, s_start, s_stop, s_tdmd, prom;
    logic [23:0] iaddr;
    logic [2:0]  busctl;
    logic [63:0] filt;

    always #5 clk = ~clk;

    nic_csr_file u_nic_csr_file (
        .clk(clk), .rst(rst), .host_we(we), .host_port(port), .host_wdata(wd),
        .host_rdata(rdata),
        .init_done_i(ev[0]), .tx_done_i(ev[1]), .rx_done_i(ev[2]), .mem_err_i(ev[3]),
        .miss_i(ev[4]), .carrier_err_i(ev[5]), .babble_i(ev[6]),
        .irq_o(irq), .init_strobe_o(s_init), .start_strobe_o(s_start),
        .stop_strobe_o(s_stop), .tx_demand_strobe_o(s_tdmd),
        .init_addr_o(iaddr), .bus_ctl_o(busctl), .mcast_filter_o(filt), .promisc_o(prom)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit        m_init, m_strt, m_stop, m_tdmd, m_txon, m_rxon, m_inea;
    bit [6:0]  m_fl;
    int        m_ptr;
    bit [15:0] m_lo;
    bit [7:0]  m_hi;
    bit [2:0]  m_bus;
    bit [15:0] m_filt [4];
    bit        m_prom;
    bit        e_init, e_start, e_stop, e_tdmd;

    function automatic bit m_err();  return |m_fl[6:3]; endfunction
    function automatic bit m_intr(); return m_err() | (|m_fl[2:0]); endfunction
    function automatic bit [15:0] m_status();
        return {m_err(), m_fl, m_intr(), m_inea, m_rxon, m_txon, m_tdmd, m_stop, m_strt, m_init};
    endfunction
    function automatic bit [15:0] m_read();
        if (port) return 16'(m_ptr);
        case (m_ptr)
            0:  return m_status();
            1:  return m_lo;
            2:  return {8'h00, m_hi};
            3:  return {13'h0, m_bus};
            8, 9, 10, 11: return m_filt[m_ptr-8];
            15: return {m_prom, 15'h0};
            default: return 16'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            {m_init, m_strt, m_tdmd, m_txon, m_rxon, m_inea} = '0;
            m_stop = 1; m_fl = 0; m_ptr = 0; m_lo = 0; m_hi = 0; m_bus = 0; m_prom = 0;
            foreach (m_filt[k]) m_filt[k] = 0;
            {e_init, e_start, e_stop, e_tdmd} = '0;
        end else begin
            bit wr0, wrx, was_stopped;
            int sel;
            wr0 = we && !port && m_ptr == 0;
            wrx = we && !port && m_ptr != 0 && m_stop;
            was_stopped = m_stop;
            sel = m_ptr;
            {e_init, e_start, e_stop, e_tdmd} = '0;
            if (wr0) m_fl = m_fl & ~wd[14:8];
            if (!was_stopped) begin
                m_fl = m_fl | ev;
                if (ev[1]) m_tdmd = 0;
            end
            if (we && port) m_ptr = int'(wd[3:0]);
            if (wr0) begin
                m_inea = wd[6];
                if (wd[2]) begin
                    m_stop = 1; m_init = 0; m_strt = 0; m_tdmd = 0;
                    m_txon = 0; m_rxon = 0; m_fl = 0; m_bus = 0; e_stop = 1;
                end else begin
                    if (wd[0]) begin m_init = 1; m_stop = 0; e_init = 1; end
                    if (wd[1]) begin m_strt = 1; m_stop = 0; m_txon = 1; m_rxon = 1; e_start = 1; end
                    if (wd[3] && !m_stop) begin m_tdmd = 1; e_tdmd = 1; end
                end
            end
            if (wrx) begin
                case (sel)
                    1: m_lo = wd;
                    2: m_hi = wd[7:0];
                    3: m_bus = wd[2:0];
                    8, 9, 10, 11: m_filt[sel-8] = wd;
                    15: m_prom = wd[15];
                    default: ;
                endcase
            end
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            check("R8 host_rdata", rdata, m_read());
            check("R6 irq_o", irq, m_intr() & m_inea);
            check("R7 strobes", {s_init, s_start, s_stop, s_tdmd}, {e_init, e_start, e_stop, e_tdmd});
            check("R9 init_addr_o", iaddr, {m_hi, m_lo});
            check("R4 bus_ctl_o", busctl, m_bus);
            check("R10 mcast_filter_o", filt, {m_filt[3], m_filt[2], m_filt[1], m_filt[0]});
            check("R10 promisc_o", prom, m_prom);
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(bit w, bit p, logic [15:0] d, logic [6:0] e);
        @(negedge clk);
        we = w; port = p; wd = d; ev = e;
        @(negedge clk);
        we = 0; ev = '0;
    endtask

    task automatic put(bit p, logic [15:0] d);
        cyc(1'b1, p, d, 7'h00);
    endtask

    task automatic see(string tag, logic [15:0] exp);
        @(negedge clk);
        port = 0;
        #2;
        check(tag, rdata, exp);
    endtask

    task automatic see_ptr(string tag, logic [15:0] exp);
        @(negedge clk);
        port = 1;
        #2;
        check(tag, rdata, exp);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        see("R1 reset status word", 16'h0004);
        check("R1 reset irq and strobes", {irq, s_init, s_start, s_stop, s_tdmd}, 5'b0);
        see_ptr("R1 reset pointer", 16'h0000);

        // configuration while stopped
        put(1, 3);  put(0, 16'h0007);
        put(1, 1);  put(0, 16'h1234);
        put(1, 2);  put(0, 16'h00AB);
        for (int i = 0; i < 4; i++) begin
            put(1, 16'(8 + i));
            put(0, 16'hA000 + 16'(i));
        end
        put(1, 15); put(0, 16'h8000);
        put(1, 5);  put(0, 16'hFFFF);
        see("R8 unmapped register reads zero", 16'h0000);
        see_ptr("R8 pointer readback", 16'h0005);
        check("R9 init address", iaddr, 24'hAB1234);
        check("R10 filter words", filt, 64'hA003_A002_A001_A000);
        check("R10 promiscuous", prom, 1'b1);
        put(1, 3);  see("R9 bus control", 16'h0007);
        put(1, 2);  see("R9 address high", 16'h00AB);

        // init and start
        put(1, 0);
        put(0, 16'h0041);
        see("R2 init latched", 16'h0041);
        put(1, 3);  see("R4 bus control kept without stop", 16'h0007);
        put(1, 0);
        cyc(0, 0, 16'h0, 7'b000_0001);
        see("R5 init-done flag", 16'h01C1);
        check("R6 irq with enable", irq, 1'b1);
        put(0, 16'h0140);
        see("R5 write-one clears flag", 16'h0041);
        put(0, 16'h0042);
        see("R2 start sets on bits", 16'h0073);

        // locked configuration while running
        put(1, 1);  put(0, 16'hBEEF);
        check("R11 address locked while running", iaddr, 24'hAB1234);
        put(1, 3);  put(0, 16'h0000);
        see("R11 bus control locked", 16'h0007);
        put(1, 0);

        // transmit demand and events
        put(0, 16'h0048);
        see("R7 transmit demand latched", 16'h007B);
        cyc(0, 0, 16'h0, 7'b000_0010);
        see("R7 tx-done clears demand", 16'h02F3);
        cyc(0, 0, 16'h0, 7'b100_0000);
        see("R6 error summary", 16'hC2F3);
        put(0, 16'h80B0);
        see("R2 read-only bits untouched", 16'hC2B3);
        check("R6 irq masked", irq, 1'b0);
        cyc(1, 0, 16'h0400, 7'b000_0100);
        see("R5 event beats clear", 16'hC6B3);
        put(0, 16'h4000);
        see("R6 error summary drops", 16'h06B3);

        // stop priority
        put(0, 16'h0005);
        see("R3 stop over init", 16'h0004);
        put(1, 3);  see("R4 stop clears bus control", 16'h0000);
        check("R10 filter survives stop", filt, 64'hA003_A002_A001_A000);
        put(1, 0);
        cyc(0, 0, 16'h0, 7'h7F);
        see("R5 events ignored while stopped", 16'h0004);
        put(0, 16'h0008);
        see("R7 demand ignored while stopped", 16'h0004);
        put(0, 16'h004A);
        see("R7 start with demand", 16'h007A);
        put(0, 16'h004F);
        see("R3 stop keeps written enable", 16'h0044);

        repeat (2) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule